// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a 10BASE-T twisted-pair link is fit to carry traffic, and it produces the idle link pulses that the local transmitter puts on the line. A line-side qualifier delivers one-cycle strobes for each good received link pulse and for each good received packet. From these strobes the block keeps a two-state view of the link, either failed or passing. That view drives a link LED and a gate that the surrounding transceiver uses to enable or block its transmit, receive, loopback and collision detection paths.

Whatever the link state, the block emits a short pulse every period while the local transmitter is idle. A strap can switch the receive-side check off, which leaves the data paths open. A loopback test flag pins the link in the passing state, and leaving loopback knocks the link back to failed. Every timer is a parameter counted in clock cycles, so a bench can use scaled values.

Top module: `link_integrity`

## Requirements
- R1: While `rst_n` is low and just after it rises, `link_ok` is 0, `link_led_n` is 1, `tx_lp_stb` is 0, and with `lt_en` high `path_en` is 0.
- R2: In the failed state, `PASS_CNT` received link pulses in which each one follows the previous one by at most `GAP_MAX_CYC` clock cycles set `link_ok` to 1 in the cycle after the last of them. One pulse fewer leaves it at 0.
- R3: In the failed state, a single `rx_pkt_ok` strobe sets `link_ok` to 1 in the next cycle.
- R4: A link pulse that arrives more than `GAP_MAX_CYC` cycles after the previous one counts as the first of a new run. The run needs `PASS_CNT` further pulses, this one included.
- R5: In the passing state, each link pulse or packet strobe restarts the loss timer. If no further strobe arrives, `link_ok` falls to 0 exactly `LOSS_CYC` cycles after the last strobe.
- R6: `path_en` is 1 when the link is passing or when `lt_en` is 0. In the failed state with `lt_en` at 1, it is 0.
- R7: `link_led_n` is 0 exactly when `link_ok` is 1.
- R8: While `tx_busy` is 0, `tx_lp_stb` is high for `WIDTH_CYC` cycles once every `PERIOD_CYC` cycles. The first pulse starts `PERIOD_CYC` cycles after reset is released. This does not depend on `lt_en` or on the link state.
- R9: `tx_lp_stb` is 0 from the cycle after `tx_busy` is sampled high and stays 0 while `tx_busy` stays high. The next pulse starts `PERIOD_CYC` cycles after the last cycle in which `tx_busy` was high.
- R10: While `lb_test` is 1, `link_ok` is 1 from the next cycle on, with or without received strobes.
- R11: In the cycle after `lb_test` falls, `link_ok` is 0, even if a packet strobe arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_lp_stb | input | 1 | One-cycle strobe for a qualified received link pulse |
| rx_pkt_ok | input | 1 | One-cycle strobe for a valid received packet |
| tx_busy | input | 1 | Local transmit activity |
| lt_en | input | 1 | Receive link check enable strap, active high |
| lb_test | input | 1 | Loopback test mode flag |
| link_ok | output | 1 | Link is in the passing state |
| link_led_n | output | 1 | Link LED drive, low when passing |
| tx_lp_stb | output | 1 | Idle link pulse to transmit |
| path_en | output | 1 | Enable for data paths and collision detection |

## Verification
A pulse counter that is off by one shows up as `link_ok` rising one pulse early or late. A gap check that is off by one shows up as a pulse spaced exactly at the limit being accepted or refused, and that difference is visible in the cycle after the fifth pulse. An error in the loss timer moves the fall of `link_ok` away from exactly `LOSS_CYC` cycles after the last strobe. Errors in the pulse generator phase or width, or a wrong restart after `tx_busy`, shift the edges of `tx_lp_stb` within one period. A missed forced state at loopback entry or exit is seen on `link_ok` one cycle later.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    typedef enum logic {
        LNK_FAIL = 1'b0,
        LNK_PASS = 1'b1
    } lnk_state_e;
endpackage

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen #(
    parameter int PERIOD_CYC = 160000,
    parameter int WIDTH_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_busy,
    output logic pulse
);
    localparam int PW = $clog2(PERIOD_CYC);
    localparam int WW = $clog2(WIDTH_CYC + 1);
    localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_CYC - 1);
    localparam logic [WW-1:0] WID_LOAD = WW'(WIDTH_CYC);

    typedef struct packed {
        logic [PW-1:0] per;
        logic [WW-1:0] wid;
    } gen_s;

    gen_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tx_busy) begin
            s_d.per = '0;
            s_d.wid = '0;
        end else begin
            if (s_q.wid != '0)
                s_d.wid = s_q.wid - 1'b1;
            if (s_q.per == PER_LAST) begin
                s_d.per = '0;
                s_d.wid = WID_LOAD;
            end else begin
                s_d.per = s_q.per + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse = (s_q.wid != '0);

    // R9: transmit activity silences the idle pulse in the next cycle
    p_quiet_on_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> !pulse);

    // R8: a pulse only begins when the period counter has just wrapped
    p_start_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> (s_q.per == '0));
endmodule

// File: rtl/lnk_state_ctl.sv
module lnk_state_ctl
    import lnk_pkg::*;
#(
    parameter int LOSS_CYC    = 1000000,
    parameter int GAP_MAX_CYC = 240000,
    parameter int PASS_CNT    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_lp_stb,
    input  logic rx_pkt_ok,
    input  logic lb_test,
    output logic pass
);
    localparam int LW = $clog2(LOSS_CYC);
    localparam int GW = $clog2(GAP_MAX_CYC + 1);
    localparam int CW = $clog2(PASS_CNT + 1);
    localparam logic [LW-1:0] LOSS_LAST = LW'(LOSS_CYC - 1);
    localparam logic [GW-1:0] GAP_LIM   = GW'(GAP_MAX_CYC);
    localparam logic [CW-1:0] CNT_LAST  = CW'(PASS_CNT - 1);

    typedef struct packed {
        lnk_state_e    st;
        logic          lb_prev;
        logic [CW-1:0] cnt;
        logic [GW-1:0] gap;
        logic [LW-1:0] loss;
    } ctl_s;

    ctl_s s_d, s_q;
    logic          lb_exit;
    logic          activity;
    logic [CW-1:0] cnt_base;

    always_comb begin
        s_d      = s_q;
        lb_exit  = s_q.lb_prev && !lb_test;
        activity = rx_lp_stb || rx_pkt_ok;
        cnt_base = (s_q.gap == GAP_LIM) ? '0 : s_q.cnt;

        s_d.lb_prev = lb_test;
        if (rx_lp_stb)
            s_d.gap = '0;
        else if (s_q.gap != GAP_LIM)
            s_d.gap = s_q.gap + 1'b1;

        if (lb_test) begin
            s_d.st   = LNK_PASS;
            s_d.cnt  = '0;
            s_d.loss = '0;
        end else if (lb_exit) begin
            s_d.st   = LNK_FAIL;
            s_d.cnt  = '0;
            s_d.loss = '0;
        end else if (s_q.st == LNK_FAIL) begin
            if (rx_pkt_ok) begin
                s_d.st  = LNK_PASS;
                s_d.cnt = '0;
            end else if (rx_lp_stb) begin
                if (cnt_base == CNT_LAST) begin
                    s_d.st  = LNK_PASS;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = cnt_base + 1'b1;
                end
            end
            s_d.loss = '0;
        end else begin
            if (activity)
                s_d.loss = '0;
            else if (s_q.loss == LOSS_LAST) begin
                s_d.st   = LNK_FAIL;
                s_d.loss = '0;
            end else
                s_d.loss = s_q.loss + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= LNK_FAIL;
        end else begin
            s_q <= s_d;
        end
    end

    assign pass = (s_q.st == LNK_PASS);

    // R1: reset always leaves the link failed
    p_reset_fail_r1: assert property (@(posedge clk)
        !rst_n |=> !pass);

    // R2, R3, R10: the link only comes up after evidence or loopback
    p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass) |-> $past(rx_lp_stb || rx_pkt_ok || lb_test));

    // R3: a packet in the failed state brings the link up
    p_pkt_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && rx_pkt_ok && !lb_exit) |=> pass);

    // R5: no loss while strobes keep arriving
    p_no_loss_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && activity && !lb_exit) |=> pass);

    // R10: loopback holds the link up
    p_loop_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lb_test |=> pass);

    // R11: leaving loopback drops the link
    p_loop_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lb_test) |=> !pass);
endmodule

// File: rtl/link_integrity.sv
module link_integrity #(
    parameter int PERIOD_CYC  = 160000,
    parameter int WIDTH_CYC   = 1,
    parameter int LOSS_CYC    = 1000000,
    parameter int GAP_MAX_CYC = 240000,
    parameter int PASS_CNT    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_lp_stb,
    input  logic rx_pkt_ok,
    input  logic tx_busy,
    input  logic lt_en,
    input  logic lb_test,
    output logic link_ok,
    output logic link_led_n,
    output logic tx_lp_stb,
    output logic path_en
);
    logic pass;

    lnk_state_ctl #(
        .LOSS_CYC   (LOSS_CYC),
        .GAP_MAX_CYC(GAP_MAX_CYC),
        .PASS_CNT   (PASS_CNT)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_lp_stb(rx_lp_stb),
        .rx_pkt_ok(rx_pkt_ok),
        .lb_test  (lb_test),
        .pass     (pass)
    );

    lnk_pulse_gen #(
        .PERIOD_CYC(PERIOD_CYC),
        .WIDTH_CYC (WIDTH_CYC)
    ) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_busy(tx_busy),
        .pulse  (tx_lp_stb)
    );

    assign link_ok    = pass;
    assign link_led_n = ~pass;
    assign path_en    = pass | ~lt_en;

    // R6: with the check enabled, a failed link never leaves the paths open
    p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_en && $fell(link_ok)) |-> !path_en);
endmodule

// File: tb/link_integrity_test.sv
module link_integrity_test;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 40;
    localparam int W    = 3;
    localparam int LOSS = 60;
    localparam int GAP  = 20;
    localparam int NP   = 5;

    logic clk = 1'b0;
    logic rst_n, rx_lp_stb, rx_pkt_ok, tx_busy, lt_en, lb_test;
    logic link_ok, link_led_n, tx_lp_stb, path_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_integrity #(
        .PERIOD_CYC(P), .WIDTH_CYC(W), .LOSS_CYC(LOSS),
        .GAP_MAX_CYC(GAP), .PASS_CNT(NP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rx_lp_stb(rx_lp_stb), .rx_pkt_ok(rx_pkt_ok),
        .tx_busy(tx_busy), .lt_en(lt_en), .lb_test(lb_test),
        .link_ok(link_ok), .link_led_n(link_led_n), .tx_lp_stb(tx_lp_stb),
        .path_en(path_en)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lp();
        rx_lp_stb = 1'b1;
        @(negedge clk);
        rx_lp_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_lp_stb = 1'b0; rx_pkt_ok = 1'b0;
        tx_busy = 1'b0; lt_en = 1'b1; lb_test = 1'b0;
        idle(3);
        chk(link_ok, 1'b0, "R1 link_ok in reset");
        chk(link_led_n, 1'b1, "R1 led in reset");
        chk(tx_lp_stb, 1'b0, "R1 tx pulse in reset");
        chk(path_en, 1'b0, "R1 gate in reset");
        rst_n = 1'b1;
    endtask

    task automatic t_pulse_gen_r8();
        do_reset();
        lt_en = 1'b0;
        idle(P - 1); chk(tx_lp_stb, 1'b0, "R8 before first pulse");
        idle(1);     chk(tx_lp_stb, 1'b1, "R8 first pulse start");
        idle(W - 1); chk(tx_lp_stb, 1'b1, "R8 pulse last cycle");
        idle(1);     chk(tx_lp_stb, 1'b0, "R8 pulse end");
        idle(P - W); chk(tx_lp_stb, 1'b1, "R8 second pulse");
    endtask

    task automatic t_tx_busy_r9();
        do_reset();
        idle(P + 1);
        chk(tx_lp_stb, 1'b1, "R9 pulse running");
        tx_busy = 1'b1;
        idle(1);  chk(tx_lp_stb, 1'b0, "R9 cut by tx");
        idle(10); chk(tx_lp_stb, 1'b0, "R9 held low during tx");
        tx_busy = 1'b0;
        idle(P - 1); chk(tx_lp_stb, 1'b0, "R9 restart not early");
        idle(1);     chk(tx_lp_stb, 1'b1, "R9 restart after period");
    endtask

    task automatic t_pulses_r2();
        do_reset();
        for (int i = 0; i < NP - 1; i++) begin
            lp(); idle(GAP - 1);
        end
        chk(link_ok, 1'b0, "R2 one pulse short");
        chk(path_en, 1'b0, "R6 gate closed in fail");
        chk(link_led_n, 1'b1, "R7 led off in fail");
        lp();
        chk(link_ok, 1'b1, "R2 pass after run");
        chk(link_led_n, 1'b0, "R7 led on in pass");
        chk(path_en, 1'b1, "R6 gate open in pass");
    endtask

    task automatic t_gap_r4();
        do_reset();
        for (int i = 0; i < NP - 1; i++) begin
            lp(); idle(GAP - 1);
        end
        idle(1);
        for (int i = 0; i < NP - 1; i++) begin
            lp(); idle(GAP - 1);
        end
        chk(link_ok, 1'b0, "R4 late pulse restarted run");
        lp();
        chk(link_ok, 1'b1, "R4 pass after new run");
    endtask

    task automatic t_pkt_loss_r3_r5();
        do_reset();
        idle(2);
        chk(link_ok, 1'b0, "R3 fail before packet");
        rx_pkt_ok = 1'b1;
        idle(1);
        rx_pkt_ok = 1'b0;
        chk(link_ok, 1'b1, "R3 pass after packet");
        idle(30);
        lp();
        idle(LOSS - 1); chk(link_ok, 1'b1, "R5 timer restarted by pulse");
        idle(1);        chk(link_ok, 1'b0, "R5 loss at limit");
        chk(path_en, 1'b0, "R6 gate closed after loss");
    endtask

    task automatic t_bypass_r6();
        do_reset();
        lt_en = 1'b0;
        idle(1);
        chk(path_en, 1'b1, "R6 bypass opens gate");
        chk(link_ok, 1'b0, "R6 state still fail");
    endtask

    task automatic t_loop_r10_r11();
        do_reset();
        lb_test = 1'b1;
        idle(1);        chk(link_ok, 1'b1, "R10 forced pass");
        idle(3 * LOSS); chk(link_ok, 1'b1, "R10 no loss in loopback");
        lb_test = 1'b0;
        rx_pkt_ok = 1'b1;
        idle(1);
        rx_pkt_ok = 1'b0;
        chk(link_ok, 1'b0, "R11 forced fail on exit");
        idle(1);        chk(link_ok, 1'b0, "R11 stays fail");
    endtask

    initial begin
        t_pulse_gen_r8();
        t_tx_busy_r9();
        t_pulses_r2();
        t_gap_r4();
        t_pkt_loss_r3_r5();
        t_bypass_r6();
        t_loop_r10_r11();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule